// File: doc/BRIEF.md
# Two-Segment Paged Address Translator

This block converts a virtual address into a physical address using small on-chip page tables. The virtual address is cut into a page number and an in-page offset. The offset is copied straight into the low bits of the result. The page number picks one of two segments and an entry inside that segment's table. One segment fills its table from the bottom of its half of the page-number space upward. The other fills its table from the top of its half downward. Each segment has a length register. An index outside the span that the length register covers is refused before its table entry is looked at.

A request is accepted with a valid/ready handshake and answered one cycle later on a response channel that also uses valid/ready. The response carries the physical address, a fault flag and a two-bit cause. System software fills the tables and length registers through a single configuration write port.

Top module: `paged_xlate_unit`

## Requirements
- R1: After reset the response channel is idle (rspValid 0, reqReady 1). Both length registers are zero and every table entry is marked not present.
- R2: For a successful translation, the low PAGE_BITS bits of rspPaddr equal the low PAGE_BITS bits of the request address.
- R3: Page-number MSB 0 selects the upward segment. With in-segment index i, the access is in bounds when i < its length, and it uses table slot i.
- R4: Page-number MSB 1 selects the downward segment. With top = 2^(page-number width - 1), the access is in bounds when i >= top - length, and it uses table slot top-1-i.
- R5: An out-of-bounds access reports cause 01 (length violation), whatever the valid bit of any table entry.
- R6: An in-bounds access whose entry has its valid bit at 0 reports cause 10 (not present).
- R7: An in-bounds access to a valid entry reports cause 00 and rspPaddr = {frame, offset}.
- R8: When the cause is not 00, rspFault is 1 and rspPaddr is zero. When the cause is 00, rspFault is 0.
- R9: A request accepted at a clock edge is answered with rspValid 1 after that edge. While rspReady is 0 the response stays valid and unchanged, and reqReady is 0.
- R10: A length register value larger than ENTRIES behaves as ENTRIES.
- R11: A configuration write to an entry or length register in the same cycle as an accepted request does not affect that request. It applies from the next request onward.
- R12: A configuration write with cfgSelLen 0 loads {cfgValid, cfgFrame} into slot cfgIdx of segment cfgSeg. With cfgSelLen 1 it loads cfgLen into the length register of segment cfgSeg.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request can be accepted |
| reqVaddr | input | VA_W | Virtual address |
| rspValid | output | 1 | Response present |
| rspReady | input | 1 | Consumer takes response |
| rspPaddr | output | FRAME_W+PAGE_BITS | Physical address, zero on fault |
| rspFault | output | 1 | Translation failed |
| rspCause | output | 2 | 00 ok, 01 length violation, 10 not present |
| cfgWe | input | 1 | Configuration write strobe |
| cfgSelLen | input | 1 | 1 writes a length register, 0 writes a table entry |
| cfgSeg | input | 1 | Target segment, 0 upward, 1 downward |
| cfgIdx | input | clog2(ENTRIES) | Table slot |
| cfgValid | input | 1 | Valid bit for the entry |
| cfgFrame | input | FRAME_W | Frame number for the entry |
| cfgLen | input | clog2(ENTRIES+1) | Length register value |

## Verification
The bench uses the default parameters: 32-bit addresses, 12-bit offsets, 20-bit frames and 16 slots per segment. With these values the length field is five bits wide, so lengths from 17 to 31 can be written and the clamping rule becomes observable. With sixteen slots, random indices placed just inside and just outside both bounds hit every slot of both tables, including the topmost pages of the downward segment.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'b00,
    CAUSE_LENGTH = 2'b01,
    CAUSE_ABSENT = 2'b10
  } cause_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // latch a new translation result
  } xlate_strobe_t;

endpackage

// File: rtl/xlate_seg_table.sv
module xlate_seg_table #(
  parameter int ENTRIES = 16,
  parameter int FRAME_W = 20,
  parameter int IDX_W   = 4,
  parameter int LEN_W   = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               entWe,
  input  logic [IDX_W-1:0]   entIdx,
  input  logic               entValid,
  input  logic [FRAME_W-1:0] entFrame,
  input  logic               lenWe,
  input  logic [LEN_W-1:0]   lenIn,
  input  logic [IDX_W-1:0]   rdIdx,
  output logic               rdValid,
  output logic [FRAME_W-1:0] rdFrame,
  output logic [LEN_W-1:0]   effLen
);

  logic               vldQ [ENTRIES];
  logic [FRAME_W-1:0] frmQ [ENTRIES];
  logic [LEN_W-1:0]   lenQ;

  generate
    for (genvar e = 0; e < ENTRIES; e++) begin : gEnt
      always_ff @(posedge clk) begin
        if (!rstN) begin
          vldQ[e] <= 1'b0;
          frmQ[e] <= '0;
        end else if (entWe && (int'(entIdx) == e)) begin
          vldQ[e] <= entValid;
          frmQ[e] <= entFrame;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN)      lenQ <= '0;
    else if (lenWe) lenQ <= lenIn;
  end

  always_comb begin
    rdValid = 1'b0;
    rdFrame = '0;
    if (int'(rdIdx) < ENTRIES) begin
      rdValid = vldQ[rdIdx];
      rdFrame = frmQ[rdIdx];
    end
  end

  assign effLen = (lenQ > LEN_W'(ENTRIES)) ? LEN_W'(ENTRIES) : lenQ;

  // R12: a length write is visible on the following cycle
  a_r12_len_load: assert property (@(posedge clk) disable iff (!rstN)
    lenWe && (lenIn <= LEN_W'(ENTRIES)) |=> effLen == $past(lenIn));

endmodule

// File: rtl/xlate_ctrl.sv
module xlate_ctrl
  import xlate_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  output logic          reqReady,
  output logic          rspValid,
  input  logic          rspReady,
  output xlate_strobe_t stb
);

  logic rspValidQ;

  assign reqReady    = !rspValidQ || rspReady;
  assign stb.capture = reqValid && reqReady;
  assign rspValid    = rspValidQ;

  always_ff @(posedge clk) begin
    if (!rstN)              rspValidQ <= 1'b0;
    else if (stb.capture)   rspValidQ <= 1'b1;
    else if (rspReady)      rspValidQ <= 1'b0;
  end

  // R9: accepted request yields a response next cycle
  a_r9_respond: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> rspValid);

  // R9: a stalled response is not dropped
  a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspReady |=> rspValid);

  // R9: a stalled response blocks new requests
  a_r9_block: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspReady |-> !reqReady);

endmodule

// File: rtl/xlate_datapath.sv
module xlate_datapath
  import xlate_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int FRAME_W   = 20,
  parameter int ENTRIES   = 16,
  localparam int VPN_W     = VA_W - PAGE_BITS,
  localparam int SEG_IDX_W = VPN_W - 1,
  localparam int IDX_W     = $clog2(ENTRIES),
  localparam int LEN_W     = $clog2(ENTRIES + 1),
  localparam int PA_W      = FRAME_W + PAGE_BITS
) (
  input  logic               clk,
  input  logic               rstN,
  input  xlate_strobe_t      stb,
  input  logic [VA_W-1:0]    reqVaddr,
  input  logic               cfgWe,
  input  logic               cfgSelLen,
  input  logic               cfgSeg,
  input  logic [IDX_W-1:0]   cfgIdx,
  input  logic               cfgValid,
  input  logic [FRAME_W-1:0] cfgFrame,
  input  logic [LEN_W-1:0]   cfgLen,
  output logic [PA_W-1:0]    resPaddr,
  output cause_e             resCause
);

  logic [VPN_W-1:0]     vpn;
  logic                 segSel;
  logic [SEG_IDX_W-1:0] segIdx;
  logic [SEG_IDX_W-1:0] downDist;
  logic [IDX_W-1:0]     slot;
  logic                 inBounds;

  logic               segValid [2];
  logic [FRAME_W-1:0] segFrame [2];
  logic [LEN_W-1:0]   segLen   [2];

  assign vpn      = reqVaddr[VA_W-1:PAGE_BITS];
  assign segSel   = vpn[VPN_W-1];
  assign segIdx   = vpn[SEG_IDX_W-1:0];
  assign downDist = ~segIdx;  // top-1-index

  generate
    for (genvar s = 0; s < 2; s++) begin : gSeg
      xlate_seg_table #(
        .ENTRIES(ENTRIES), .FRAME_W(FRAME_W), .IDX_W(IDX_W), .LEN_W(LEN_W)
      ) uTable (
        .clk      (clk),
        .rstN     (rstN),
        .entWe    (cfgWe && !cfgSelLen && (cfgSeg == 1'(s))),
        .entIdx   (cfgIdx),
        .entValid (cfgValid),
        .entFrame (cfgFrame),
        .lenWe    (cfgWe && cfgSelLen && (cfgSeg == 1'(s))),
        .lenIn    (cfgLen),
        .rdIdx    (slot),
        .rdValid  (segValid[s]),
        .rdFrame  (segFrame[s]),
        .effLen   (segLen[s])
      );
    end
  endgenerate

  always_comb begin
    if (segSel) begin
      inBounds = downDist < SEG_IDX_W'(segLen[1]);
      slot     = downDist[IDX_W-1:0];
    end else begin
      inBounds = segIdx < SEG_IDX_W'(segLen[0]);
      slot     = segIdx[IDX_W-1:0];
    end
  end

  logic   hitValid;
  cause_e nextCause;
  logic [PA_W-1:0] nextPaddr;

  assign hitValid = segValid[segSel];

  always_comb begin
    nextCause = CAUSE_NONE;
    nextPaddr = '0;
    if (!inBounds)       nextCause = CAUSE_LENGTH;
    else if (!hitValid)  nextCause = CAUSE_ABSENT;
    else                 nextPaddr = {segFrame[segSel], reqVaddr[PAGE_BITS-1:0]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resPaddr <= '0;
      resCause <= CAUSE_NONE;
    end else if (stb.capture) begin
      resPaddr <= nextPaddr;
      resCause <= nextCause;
    end
  end

  // R8: a faulting result carries a zero address
  a_r8_fault_zero: assert property (@(posedge clk) disable iff (!rstN)
    (resCause != CAUSE_NONE) |-> (resPaddr == '0));

  // R2: the offset of a good translation is passed through
  a_r2_offset: assert property (@(posedge clk) disable iff (!rstN)
    stb.capture |=> (resCause != CAUSE_NONE) ||
      (resPaddr[PAGE_BITS-1:0] == $past(reqVaddr[PAGE_BITS-1:0])));

  // R5: out-of-range index faults as a length violation
  a_r5_bound_first: assert property (@(posedge clk) disable iff (!rstN)
    stb.capture && !inBounds |=> resCause == CAUSE_LENGTH);

  // R6: in-range invalid entry faults as not present
  a_r6_absent: assert property (@(posedge clk) disable iff (!rstN)
    stb.capture && inBounds && !hitValid |=> resCause == CAUSE_ABSENT);

endmodule

// File: rtl/paged_xlate_unit.sv
module paged_xlate_unit
  import xlate_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int FRAME_W   = 20,
  parameter int ENTRIES   = 16,
  localparam int IDX_W    = $clog2(ENTRIES),
  localparam int LEN_W    = $clog2(ENTRIES + 1),
  localparam int PA_W     = FRAME_W + PAGE_BITS
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic [VA_W-1:0]    reqVaddr,
  output logic               rspValid,
  input  logic               rspReady,
  output logic [PA_W-1:0]    rspPaddr,
  output logic               rspFault,
  output logic [1:0]         rspCause,
  input  logic               cfgWe,
  input  logic               cfgSelLen,
  input  logic               cfgSeg,
  input  logic [IDX_W-1:0]   cfgIdx,
  input  logic               cfgValid,
  input  logic [FRAME_W-1:0] cfgFrame,
  input  logic [LEN_W-1:0]   cfgLen
);

  xlate_strobe_t stb;
  cause_e        resCause;

  xlate_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqReady (reqReady),
    .rspValid (rspValid),
    .rspReady (rspReady),
    .stb      (stb)
  );

  xlate_datapath #(
    .VA_W(VA_W), .PAGE_BITS(PAGE_BITS), .FRAME_W(FRAME_W), .ENTRIES(ENTRIES)
  ) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .reqVaddr  (reqVaddr),
    .cfgWe     (cfgWe),
    .cfgSelLen (cfgSelLen),
    .cfgSeg    (cfgSeg),
    .cfgIdx    (cfgIdx),
    .cfgValid  (cfgValid),
    .cfgFrame  (cfgFrame),
    .cfgLen    (cfgLen),
    .resPaddr  (rspPaddr),
    .resCause  (resCause)
  );

  assign rspCause = resCause;
  assign rspFault = (resCause != CAUSE_NONE);

  // R9: a stalled response keeps its contents
  a_r9_stable: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspReady |=> $stable(rspPaddr) && $stable(rspCause));

endmodule

// File: tb/sim_paged_xlate_unit.sv
module sim_paged_xlate_unit;

  localparam int ENTRIES = 16;
  localparam int TOP     = 1 << 19;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqReady;
  logic [31:0] reqVaddr = '0;
  logic        rspValid, rspReady = 1'b1;
  logic [31:0] rspPaddr;
  logic        rspFault;
  logic [1:0]  rspCause;
  logic        cfgWe = 1'b0, cfgSelLen = 1'b0, cfgSeg = 1'b0;
  logic [3:0]  cfgIdx = '0;
  logic        cfgValid = 1'b0;
  logic [19:0] cfgFrame = '0;
  logic [4:0]  cfgLen = '0;

  always #10 clk = ~clk;

  paged_xlate_unit u0 (.*);

  int nChecks = 0, nFails = 0;
  bit done = 0;

  logic        mValid [2][ENTRIES];
  logic [19:0] mFrame [2][ENTRIES];
  int          mLen   [2];

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic logic [33:0] expect_of(input logic [31:0] va);
    int seg, idx, eff, slot;
    bit ok;
    seg = va[31];
    idx = int'(va[30:12]);
    eff = (mLen[seg] > ENTRIES) ? ENTRIES : mLen[seg];
    if (seg == 0) begin ok = idx < eff; slot = idx; end
    else begin slot = TOP - 1 - idx; ok = slot < eff; end
    if (!ok) return {2'b01, 32'h0};
    if (!mValid[seg][slot]) return {2'b10, 32'h0};
    return {2'b00, mFrame[seg][slot], va[11:0]};
  endfunction

  function automatic logic [31:0] mkVa(input bit seg, input int idx, input logic [11:0] off);
    return {seg, 19'(idx), off};
  endfunction

  task automatic applyModel();
    if (cfgSelLen) mLen[cfgSeg] = int'(cfgLen);
    else begin
      mValid[cfgSeg][cfgIdx] = cfgValid;
      mFrame[cfgSeg][cfgIdx] = cfgFrame;
    end
  endtask

  task automatic setEntry(input bit seg, input int idx, input bit v, input logic [19:0] f);
    @(negedge clk);
    cfgWe = 1; cfgSelLen = 0; cfgSeg = seg; cfgIdx = 4'(idx); cfgValid = v; cfgFrame = f;
    @(posedge clk); applyModel();
    @(negedge clk); cfgWe = 0;
  endtask

  task automatic setLen(input bit seg, input int len);
    @(negedge clk);
    cfgWe = 1; cfgSelLen = 1; cfgSeg = seg; cfgLen = 5'(len);
    @(posedge clk); applyModel();
    @(negedge clk); cfgWe = 0;
  endtask

  task automatic checkRsp(input string req, input logic [33:0] e);
    chk({req, " valid"}, rspValid, 1);
    chk({req, " cause"}, rspCause, e[33:32]);
    chk({req, " paddr"}, rspPaddr, e[31:0]);
    chk({req, " fault"}, rspFault, e[33:32] != 2'b00);
  endtask

  task automatic xlate(input logic [31:0] va, input string req);
    logic [33:0] e;
    @(negedge clk);
    reqVaddr = va; reqValid = 1; rspReady = 1;
    e = expect_of(va);
    @(posedge clk);
    @(negedge clk); reqValid = 0;
    checkRsp(req, e);
  endtask

  initial begin
    void'($urandom(32'd4711));
    for (int s = 0; s < 2; s++) begin
      mLen[s] = 0;
      for (int i = 0; i < ENTRIES; i++) begin mValid[s][i] = 0; mFrame[s][i] = '0; end
    end
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    // R1 reset state
    chk("R1 rspValid", rspValid, 0);
    chk("R1 reqReady", reqReady, 1);
    xlate(mkVa(0, 0, 12'h123), "R1 zero length");
    setLen(0, 4);
    xlate(mkVa(0, 1, 12'h055), "R1 cleared valid");
    // R12 R7 R3 upward entries
    setEntry(0, 1, 1, 20'hABCDE);
    xlate(mkVa(0, 1, 12'hFED), "R7 R3 up hit");
    xlate(mkVa(0, 4, 12'h001), "R3 up bound");
    setEntry(0, 3, 1, 20'h00042);
    xlate(mkVa(0, 3, 12'h800), "R3 up last slot");
    // R5 length checked before valid bit
    setEntry(0, 5, 1, 20'h11111);
    xlate(mkVa(0, 5, 12'h0), "R5 bound before valid");
    // R4 downward segment
    setLen(1, 3);
    setEntry(1, 0, 1, 20'h77700);
    setEntry(1, 2, 1, 20'h77702);
    xlate(mkVa(1, TOP - 1, 12'h321), "R4 down top");
    xlate(mkVa(1, TOP - 3, 12'h004), "R4 down third");
    xlate(mkVa(1, TOP - 2, 12'h004), "R6 down absent");
    xlate(mkVa(1, TOP - 4, 12'h004), "R4 down bound");
    xlate(mkVa(1, 0, 12'h004), "R4 down bottom");
    // R10 clamp
    setLen(0, 31);
    setEntry(0, 15, 1, 20'h0F0F0);
    xlate(mkVa(0, 15, 12'hAAA), "R10 clamp in");
    xlate(mkVa(0, 16, 12'hAAA), "R10 clamp out");
    // R11 same-cycle entry write returns old contents
    begin
      logic [33:0] e;
      @(negedge clk);
      reqVaddr = mkVa(0, 2, 12'h5A5); reqValid = 1;
      cfgWe = 1; cfgSelLen = 0; cfgSeg = 0; cfgIdx = 2; cfgValid = 1; cfgFrame = 20'h22222;
      e = expect_of(reqVaddr);
      @(posedge clk); applyModel();
      @(negedge clk); reqValid = 0; cfgWe = 0;
      checkRsp("R11 entry old", e);
      xlate(mkVa(0, 2, 12'h5A5), "R11 entry new");
      @(negedge clk);
      reqVaddr = mkVa(0, 2, 12'h0); reqValid = 1;
      cfgWe = 1; cfgSelLen = 1; cfgSeg = 0; cfgLen = 0;
      e = expect_of(reqVaddr);
      @(posedge clk); applyModel();
      @(negedge clk); reqValid = 0; cfgWe = 0;
      checkRsp("R11 length old", e);
      xlate(mkVa(0, 2, 12'h0), "R11 length new");
    end
    // R9 backpressure
    setLen(0, 8);
    begin
      logic [31:0] held;
      @(negedge clk);
      reqVaddr = mkVa(0, 2, 12'h777); reqValid = 1; rspReady = 0;
      @(posedge clk);
      @(negedge clk); reqValid = 0;
      chk("R9 valid after accept", rspValid, 1);
      chk("R9 ready blocked", reqReady, 0);
      held = rspPaddr;
      @(posedge clk);
      @(negedge clk);
      chk("R9 held valid", rspValid, 1);
      chk("R9 held paddr", rspPaddr, held);
      rspReady = 1;
      @(posedge clk);
      @(negedge clk);
      chk("R9 drained", rspValid, 0);
    end
    // random mix, R2 R3 R4 R5 R6 R7 R8
    for (int n = 0; n < 400; n++) begin
      int pick;
      bit s;
      int k;
      pick = $urandom_range(0, 9);
      s = 1'($urandom_range(0, 1));
      if (pick == 0) setLen(s, $urandom_range(0, 20));
      else if (pick < 3)
        setEntry(s, $urandom_range(0, ENTRIES - 1), 1'($urandom_range(0, 3) != 0), 20'($urandom));
      else begin
        k = $urandom_range(0, ENTRIES + 2);
        xlate(mkVa(s, s ? TOP - 1 - k : k, 12'($urandom)), "R2 R8 random");
      end
    end
    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule